// File: doc/BRIEF.md
# Packed SIMD Multiply and Byte Absolute-Difference Unit

This unit is the packed-arithmetic part of the multiply pipe in a 32-bit DSP datapath. It takes two 32-bit source words and an opcode, and it registers one result per issue. A source word is read either as two 16-bit halfwords or as four 8-bit byte lanes. The halfword forms multiply one chosen halfword of each source as signed two's-complement values, in any of the four low/high pairings. A fractional variant of each pairing doubles the product to Q31 format and saturates the one case that overflows. The byte forms either multiply four byte pairs as unsigned numbers or return the absolute difference of each byte pair, and no lane affects another lane.

The result is due exactly one cycle after issue, which gives the single delay slot of a 16x16 multiply. A sticky saturation flag records every fractional overflow until software clears it through a clear strobe. Instruction decode, register files and operand routing stay outside the unit.

Top module: `simd_pmul_unit`

## Requirements
- R1: Opcode 4'h0 returns the signed product of src1[15:0] and src2[15:0] in res[31:0]. res[63:32] is zero for every opcode except 4'h4.
- R2: Opcode 4'h1 returns the signed product of src1[31:16] and src2[31:16] in res[31:0].
- R3: Opcode 4'h2 returns the signed product of src1[15:0] and src2[31:16] in res[31:0].
- R4: Opcode 4'h3 returns the signed product of src1[31:16] and src2[15:0] in res[31:0].
- R5: Opcodes 4'h8 to 4'hB select halfwords as opcodes 4'h0 to 4'h3 do and return twice the signed product. When both selected halfwords are 16'h8000, the result is 32'h7FFFFFFF and a saturation event occurs.
- R6: Opcode 4'h4 returns four unsigned 8x8 products in res. Byte lane k (bits 8k+7:8k) of both sources gives res[16k+15:16k], so lane 0 sits in the least significant bits.
- R7: Opcode 4'h5 returns |src1 byte k - src2 byte k| in res[8k+7:8k] for each byte lane, with no borrow between lanes, and res[63:32] is zero.
- R8: res and res_vld take the values of an issue one clock edge after issue_vld is sampled high. res_vld is low in every cycle that does not follow an issue.
- R9: In a cycle without issue_vld, res keeps its value whatever src1, src2 and opcode do.
- R10: sat_flag is set by a saturation event and stays set until sat_clr is sampled high in a cycle without a new saturation event. A saturation event in the same cycle as sat_clr leaves the flag set.
- R11: While rst_n is low, res is zero and both res_vld and sat_flag are low.
- R12: Opcodes 4'h6, 4'h7 and 4'hC to 4'hF return a zero result and cause no saturation event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | An operation is issued this cycle |
| opcode | input | 4 | Operation select |
| src1 | input | 32 | First packed source word |
| src2 | input | 32 | Second packed source word |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| res | output | 64 | Registered result |
| res_vld | output | 1 | res holds a result issued in the previous cycle |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every result, its valid strobe and its effect on the saturation flag appear one clock edge after the issue edge. The bench drives each operation at a falling edge and compares the outputs at the next falling edge, which comes after exactly one rising edge. It issues back-to-back operations every cycle, so a result that arrives a cycle early or late meets the wrong expected value. Checks of holding and clearing drop issue_vld for one cycle and look at the outputs at the following falling edge.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MUL_LL  = 4'h0,
    OP_MUL_HH  = 4'h1,
    OP_MUL_LH  = 4'h2,
    OP_MUL_HL  = 4'h3,
    OP_QMULU   = 4'h4,
    OP_QABSD   = 4'h5,
    OP_FMUL_LL = 4'h8,
    OP_FMUL_HH = 4'h9,
    OP_FMUL_LH = 4'hA,
    OP_FMUL_HL = 4'hB
  } simd_op_e;

endpackage

// File: rtl/simd_halfmul.sv
// Signed halfword multiplier with operand selection and optional Q15 doubling.
module simd_halfmul #(
  parameter int unsigned WORD_W = simd_pkg::WORD_W
) (
  input  logic [WORD_W-1:0] src1,
  input  logic [WORD_W-1:0] src2,
  input  logic              take_hi1,
  input  logic              take_hi2,
  input  logic              frac,
  output logic [WORD_W-1:0] prod,
  output logic              sat
);
  localparam int unsigned HALF_W = WORD_W / 2;

  logic signed [HALF_W-1:0] opa;
  logic signed [HALF_W-1:0] opb;
  logic signed [WORD_W-1:0] raw;
  logic        [WORD_W-1:0] dbl;
  logic        [WORD_W-1:0] ovf_val;
  logic        [WORD_W-1:0] max_pos;

  always_comb begin
    opa     = take_hi1 ? src1[WORD_W-1:HALF_W] : src1[HALF_W-1:0];
    opb     = take_hi2 ? src2[WORD_W-1:HALF_W] : src2[HALF_W-1:0];
    raw     = opa * opb;
    dbl     = {raw[WORD_W-2:0], 1'b0};
    // Only (-1.0)*(-1.0) produces this raw product; doubling it overflows.
    ovf_val = {2'b01, {(WORD_W-2){1'b0}}};
    max_pos = {1'b0, {(WORD_W-1){1'b1}}};
    sat     = frac && (raw == ovf_val);
    if (!frac)    prod = raw;
    else if (sat) prod = max_pos;
    else          prod = dbl;
  end

endmodule

// File: rtl/simd_bytelane.sv
// One byte lane: unsigned product and absolute difference.
module simd_bytelane #(
  parameter int unsigned BYTE_W = simd_pkg::BYTE_W
) (
  input  logic [BYTE_W-1:0]   a,
  input  logic [BYTE_W-1:0]   b,
  output logic [2*BYTE_W-1:0] prod,
  output logic [BYTE_W-1:0]   absd
);
  logic [BYTE_W:0] diff;

  always_comb begin
    prod = a * b;
    diff = {1'b0, a} - {1'b0, b};
    absd = diff[BYTE_W] ? (b - a) : diff[BYTE_W-1:0];
  end

endmodule

// File: rtl/simd_pmul_unit.sv
module simd_pmul_unit #(
  parameter int unsigned WORD_W = simd_pkg::WORD_W,
  parameter int unsigned BYTE_W = simd_pkg::BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_vld,
  input  logic [3:0]            opcode,
  input  logic [WORD_W-1:0]     src1,
  input  logic [WORD_W-1:0]     src2,
  input  logic                  sat_clr,
  output logic [2*WORD_W-1:0]   res,
  output logic                  res_vld,
  output logic                  sat_flag
);
  import simd_pkg::*;

  localparam int unsigned LANES = WORD_W / BYTE_W;
  localparam int unsigned RES_W = 2 * WORD_W;

  logic [WORD_W-1:0] hm_prod;
  logic              hm_sat;
  logic              take_hi1;
  logic              take_hi2;
  logic              is_frac;
  logic [RES_W-1:0]  qmul_word;
  logic [WORD_W-1:0] qabs_word;

  logic [RES_W-1:0]  res_d,  res_q;
  logic              vld_d,  vld_q;
  logic              sat_d,  sat_q;
  logic              sat_hit;

  // Halfword pairing from opcode[1:0]: 00 low/low, 01 high/high,
  // 10 low(src1)/high(src2), 11 high(src1)/low(src2).
  always_comb begin
    take_hi1 = (opcode[1:0] == 2'b01) || (opcode[1:0] == 2'b11);
    take_hi2 = (opcode[1:0] == 2'b01) || (opcode[1:0] == 2'b10);
    is_frac  = opcode[3];
  end

  simd_halfmul #(.WORD_W(WORD_W)) u_hmul (
    .src1     (src1),
    .src2     (src2),
    .take_hi1 (take_hi1),
    .take_hi2 (take_hi2),
    .frac     (is_frac),
    .prod     (hm_prod),
    .sat      (hm_sat)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    simd_bytelane #(.BYTE_W(BYTE_W)) u_lane (
      .a    (src1[k*BYTE_W +: BYTE_W]),
      .b    (src2[k*BYTE_W +: BYTE_W]),
      .prod (qmul_word[k*2*BYTE_W +: 2*BYTE_W]),
      .absd (qabs_word[k*BYTE_W +: BYTE_W])
    );
  end

  // Next-state logic
  always_comb begin
    res_d   = '0;
    sat_hit = 1'b0;
    case (simd_op_e'(opcode))
      OP_MUL_LL, OP_MUL_HH, OP_MUL_LH, OP_MUL_HL:
        res_d = {{WORD_W{1'b0}}, hm_prod};
      OP_FMUL_LL, OP_FMUL_HH, OP_FMUL_LH, OP_FMUL_HL: begin
        res_d   = {{WORD_W{1'b0}}, hm_prod};
        sat_hit = hm_sat;
      end
      OP_QMULU: res_d = qmul_word;
      OP_QABSD: res_d = {{WORD_W{1'b0}}, qabs_word};
      default:  res_d = '0;
    endcase
    vld_d = issue_vld;
    sat_d = (sat_q && !sat_clr) || (issue_vld && sat_hit);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      if (issue_vld) res_q <= res_d;
      vld_q <= vld_d;
      sat_q <= sat_d;
    end
  end

  assign res      = res_q;
  assign res_vld  = vld_q;
  assign sat_flag = sat_q;

endmodule

// File: rtl/simd_pmul_chk.sv
module simd_pmul_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                issue_vld,
  input logic [3:0]          opcode,
  input logic [WORD_W-1:0]   src1,
  input logic [WORD_W-1:0]   src2,
  input logic                sat_clr,
  input logic [2*WORD_W-1:0] res,
  input logic                res_vld,
  input logic                sat_flag
);

  p_issue_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> res_vld);

  p_idle_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> !res_vld);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(res));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !issue_vld) |=> !sat_flag);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && opcode != 4'h4) |=> (res[2*WORD_W-1:WORD_W] == '0));

  p_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && opcode == 4'h4) |=>
      (res[15:0] == 16'($past(src1[7:0]) * $past(src2[7:0]))));

  p_ll_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && opcode == 4'h0) |=>
      (res[WORD_W-1:0] == WORD_W'($signed($past(src1[15:0])) * $signed($past(src2[15:0])))));

  p_undef_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (opcode == 4'h6 || opcode == 4'h7 || opcode[3:2] == 2'b11)) |=> (res == '0));

endmodule

bind simd_pmul_unit simd_pmul_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_vld (issue_vld),
  .opcode    (opcode),
  .src1      (src1),
  .src2      (src2),
  .sat_clr   (sat_clr),
  .res       (res),
  .res_vld   (res_vld),
  .sat_flag  (sat_flag)
);

// File: tb/sim_simd_pmul_unit.sv
module sim_simd_pmul_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_vld = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] src1 = '0;
  logic [31:0] src2 = '0;
  logic        sat_clr = 1'b0;
  logic [63:0] res;
  logic        res_vld;
  logic        sat_flag;

  int nvec = 0;
  int nerr = 0;
  logic exp_sat = 1'b0;

  always #4 clk = ~clk;

  simd_pmul_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .opcode(opcode),
    .src1(src1), .src2(src2), .sat_clr(sat_clr),
    .res(res), .res_vld(res_vld), .sat_flag(sat_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected halfword result; sets s on fractional overflow.
  function automatic logic [63:0] ref_half(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, output logic s);
    logic [15:0] ha, hb;
    longint p;
    ha = (op[1:0] == 2'b01 || op[1:0] == 2'b11) ? a[31:16] : a[15:0];
    hb = (op[1:0] == 2'b01 || op[1:0] == 2'b10) ? b[31:16] : b[15:0];
    p  = longint'($signed(ha)) * longint'($signed(hb));
    s  = 1'b0;
    if (op[3]) begin
      p = p * 2;
      if (p > 64'sd2147483647) begin
        p = 64'sd2147483647;
        s = 1'b1;
      end
    end
    return {32'h0, p[31:0]};
  endfunction

  function automatic logic [63:0] ref_quad(input logic absd, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      int x, y;
      x = int'(a[8*k +: 8]);
      y = int'(b[8*k +: 8]);
      if (absd) r[8*k +: 8] = 8'((x > y) ? x - y : y - x);
      else      r[16*k +: 16] = 16'(x * y);
    end
    return r;
  endfunction

  // Drive at a falling edge, result is due at the next falling edge.
  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    issue_vld = 1'b1;
    opcode    = op;
    src1      = a;
    src2      = b;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] hv [8];
    string tags [4];
    hv[0] = 16'h0000; hv[1] = 16'h0001; hv[2] = 16'h7FFF; hv[3] = 16'h8000;
    hv[4] = 16'hFFFF; hv[5] = 16'h1234; hv[6] = 16'hABCD; hv[7] = 16'h00FF;
    tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4";

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 res", res, 64'h0);
    chk("R11 res_vld", {63'h0, res_vld}, 64'h0);
    chk("R11 sat_flag", {63'h0, sat_flag}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle res_vld", {63'h0, res_vld}, 64'h0);

    // Halfword sweep: every pairing, integer and fractional, back to back
    for (int f = 0; f < 2; f++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            logic [3:0]  op;
            logic [31:0] a, b;
            logic [63:0] e;
            logic s;
            op = {f[0], 1'b0, sel[1:0]};
            a  = {hv[i], hv[(i + 5) % 8]};
            b  = {hv[j], hv[(j + 2) % 8]};
            e  = ref_half(op, a, b, s);
            issue(op, a, b);
            exp_sat = exp_sat | s;
            if (f == 0) chk(tags[sel], res, e);
            else        chk("R5", res, e);
            chk("R8 res_vld", {63'h0, res_vld}, 64'h1);
            chk("R10 sat_flag", {63'h0, sat_flag}, {63'h0, exp_sat});
          end
        end
      end
    end

    // R9: no issue, inputs change, result holds
    begin
      logic [63:0] held;
      held = res;
      issue_vld = 1'b0;
      opcode = 4'h4;
      src1 = 32'hFFFFFFFF;
      src2 = 32'h12345678;
      @(negedge clk);
      chk("R9 hold", res, held);
      chk("R8 no issue res_vld", {63'h0, res_vld}, 64'h0);
    end

    // R10: clear, then saturation together with clear
    chk("R10 flag set before clear", {63'h0, sat_flag}, 64'h1);
    sat_clr = 1'b1;
    @(negedge clk);
    chk("R10 cleared", {63'h0, sat_flag}, 64'h0);
    issue(4'h8, 32'h00008000, 32'h00008000);
    chk("R5 saturated value", res, 64'h000000007FFFFFFF);
    chk("R10 set wins over clear", {63'h0, sat_flag}, 64'h1);
    sat_clr = 1'b0;
    issue(4'h0, 32'h00008000, 32'h00008000);
    chk("R1 no sat in integer form", res, 64'h0000000040000000);
    chk("R10 sticky", {63'h0, sat_flag}, 64'h1);
    issue_vld = 1'b0;
    sat_clr = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0;
    chk("R10 cleared again", {63'h0, sat_flag}, 64'h0);

    // R12: undefined opcodes give zero and no saturation
    for (int u = 0; u < 6; u++) begin
      logic [3:0] op;
      op = (u < 2) ? 4'(6 + u) : 4'(12 + u - 2);
      issue(op, 32'h80008000, 32'h80008000);
      chk("R12 zero result", res, 64'h0);
      chk("R12 no sat", {63'h0, sat_flag}, 64'h0);
    end

    // Byte-lane sweep: quad unsigned multiply and quad absolute difference
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) begin
        for (int j = 0; j < 256; j += 3) begin
          logic [31:0] a, b;
          logic [7:0] bi, bj;
          bi = 8'(i);
          bj = 8'(j);
          a = {8'(i * 7), 8'hFF - bi, bi ^ 8'hA5, bi};
          b = {8'(j * 5 + 1), bj ^ 8'h3C, 8'hFF - bj, bj};
          issue(m == 0 ? 4'h4 : 4'h5, a, b);
          if (m == 0) chk("R6", res, ref_quad(1'b0, a, b));
          else        chk("R7", res, ref_quad(1'b1, a, b));
        end
      end
    end

    issue_vld = 1'b0;
    @(negedge clk);
    chk("R8 res_vld drops", {63'h0, res_vld}, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule